// File: doc/BRIEF.md
# Run-Time Selectable Sample Delay

This block delays a stream of data words by a number of clock cycles chosen while it runs. Every enabled clock edge pushes the input word into a chain of registers, one register per cycle of delay, and a selector routes one point of that chain to the output. A select value of zero skips the chain entirely, so the output follows the input in the same cycle. Any value from 1 up to the chain length gives the word that entered that many enabled edges earlier.

The enable input gates the whole chain. A held chain keeps its contents, so the output stays fixed while the select stays fixed. The select may change on any cycle. The output then moves at once to the newly chosen point, and no stored data is lost. Typical uses are aligning one data path with another of known latency, or trimming skew between channels.

The reset input is asynchronous and active low. Asserting it clears the chain at once. Its release is synchronised inside the block, so the chain stays cleared for two further clock edges.

Top module: `sel_delay_line`

## Requirements
- R1: While reset is asserted, and after its release until the first enabled edge, the output is all zeros for every non-zero select value.
- R2: With select equal to 0, the output equals the input in the same cycle, with no register in the path.
- R3: With select equal to k, where 1 <= k <= DEPTH, the output equals the input word captured at the k-th most recent clock edge on which enable was high. If fewer than k such edges have occurred since reset, the output is zero.
- R4: A clock edge with enable low changes no stage. With the select held, the output stays unchanged across such edges whatever the input does.
- R5: A new select value reaches the output in the same cycle it is applied, and changing the select leaves the stored words untouched.
- R6: The longest delay, select equal to DEPTH (63 by default), returns the word from DEPTH enabled edges earlier.
- R7: Asserting reset in the middle of operation clears the output at once, without waiting for a clock edge. The internal reset is then held for two clock edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Shift enable for the chain |
| din | input | W | Input data word |
| delay_sel | input | SEL_W | Delay in cycles, 0 to DEPTH |
| dout | output | W | Delayed data word |

## Verification
The bench uses the default build: 16-bit words and a 63-stage chain with a 6-bit select. This puts the full select range within reach, including the deepest tap, which is exercised only after more than 63 enabled edges have filled the chain. The reference model is a queue of words taken on enabled edges. It is checked on every cycle against runs with enable held low, selects that change on every cycle, the bypass value, and a reset asserted in the middle of traffic.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int unsigned SDL_DEF_WIDTH = 16;
  localparam int unsigned SDL_DEF_DEPTH = 63;

  function automatic int unsigned sdl_sel_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/sdl_rst_sync.sv
module sdl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sdl_chain.sv
module sdl_chain #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 63
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps
);
  logic [DEPTH-1:0][W-1:0] stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (en) begin
      stage_d[0] = din;
      for (int i = 1; i < DEPTH; i++) stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign taps = stage_q;

  // R3: the first stage captures the input on an enabled edge
  assert_head_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> stage_q[0] == $past(din));

  // R4: a disabled edge leaves every stage untouched
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(stage_q));

  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_link
      // R3: each stage takes its neighbour's previous value on an enabled edge
      assert_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> stage_q[g] == $past(stage_q[g-1]));
    end
  endgenerate
endmodule

// File: rtl/sdl_tap_mux.sv
module sdl_tap_mux #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 63,
  parameter int unsigned SEL_W = 6
) (
  input  logic [W-1:0]             din,
  input  logic [DEPTH-1:0][W-1:0]  taps,
  input  logic [SEL_W-1:0]         sel,
  output logic [W-1:0]             dout
);
  always_comb begin
    dout = din;
    if (sel > SEL_W'(DEPTH)) dout = taps[DEPTH-1];
    for (int i = 0; i < DEPTH; i++) begin
      if (sel == SEL_W'(i + 1)) dout = taps[i];
    end
  end

  // R2: a zero select passes the input straight through
  always_comb begin
    if (sel == '0) assert_bypass_R2: assert (dout == din);
  end
endmodule

// File: rtl/sel_delay_line.sv
module sel_delay_line #(
  parameter int unsigned W     = sdl_pkg::SDL_DEF_WIDTH,
  parameter int unsigned DEPTH = sdl_pkg::SDL_DEF_DEPTH,
  parameter int unsigned SEL_W = sdl_pkg::sdl_sel_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] delay_sel,
  output logic [W-1:0]     dout
);
  logic                    core_rst_n;
  logic [DEPTH-1:0][W-1:0] taps;

  sdl_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  sdl_chain #(.W(W), .DEPTH(DEPTH)) u_chain (
    .clk   (clk),
    .rst_n (core_rst_n),
    .en    (en),
    .din   (din),
    .taps  (taps)
  );

  sdl_tap_mux #(.W(W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_mux (
    .din  (din),
    .taps (taps),
    .sel  (delay_sel),
    .dout (dout)
  );

  // R3: a one-cycle tap shows the word taken at the last enabled edge
  assert_one_tap_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($past(en) && delay_sel == SEL_W'(1)) |-> dout == $past(din));
endmodule

// File: tb/tb_sel_delay_line.sv
module tb_sel_delay_line;
  localparam int W = 16;
  localparam int DEPTH = 63;
  localparam int SEL_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] din = '0;
  logic [SEL_W-1:0] delay_sel = '0;
  logic [W-1:0] dout;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [W-1:0] hist[$];

  always #2.5 clk = ~clk;

  sel_delay_line #(.W(W), .DEPTH(DEPTH), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din),
    .delay_sel(delay_sel), .dout(dout)
  );

  // Reference: queue of words taken on enabled edges, newest first
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist.delete();
    else if (en) begin
      hist.push_front(din);
      if (hist.size() > DEPTH) void'(hist.pop_back());
    end
  end

  function automatic logic [W-1:0] expect_out(input int k);
    if (k == 0) return din;
    if (k > hist.size()) return '0;
    return hist[k-1];
  endfunction

  task automatic check(input string tag);
    logic [W-1:0] exp_v;
    exp_v = expect_out(int'(delay_sel));
    n_chk++;
    if (dout !== exp_v) begin
      n_bad++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", tag, delay_sel, dout, exp_v);
    end
  endtask

  task automatic step(input logic e, input logic [W-1:0] d, input int s, input string tag);
    @(negedge clk);
    en = e; din = d; delay_sel = SEL_W'(s);
    #1 check(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs cleared during and after reset
    for (int i = 0; i < 4; i++) step(1'b0, 16'h1234 + 16'(i), 1 + i * 20, "R1");
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 16'hBEEF, 5 + i * 19, "R1");

    // R3: fill with a varying pattern at fixed taps
    for (int i = 0; i < 20; i++) step(1'b1, 16'(i * 37 + 5), 3, "R3");
    for (int i = 0; i < 10; i++) step(1'b1, 16'(i * 911 + 1), 7, "R3");

    // R2: bypass
    for (int i = 0; i < 6; i++) step(i % 2 == 0, 16'(16'hA5A5 ^ i), 0, "R2");

    // R4: enable low, input moving, taps held
    for (int i = 0; i < 8; i++) step(1'b0, 16'(i * 4099), 4, "R4");
    for (int i = 0; i < 30; i++) step((i % 3) == 0, 16'(i * 123 + 77), 2, "R4");

    // R5: select changes every cycle, contents kept
    for (int i = 0; i < 40; i++) step(1'b0, 16'hFFFF, (i * 13) % 31, "R5");
    for (int i = 0; i < 40; i++) step(i % 2 == 1, 16'(i * 7), (i * 5) % 40, "R5");

    // R6: fill beyond the chain length and read the deepest tap
    for (int i = 0; i < 80; i++) step(1'b1, 16'(i * 251 + 3), DEPTH, "R6");
    for (int i = 0; i < 5; i++) step(1'b0, 16'h0, DEPTH, "R6");

    // R7: reset in mid-traffic clears at once
    @(negedge clk);
    delay_sel = SEL_W'(5);
    rst_n = 1'b0;
    #1 check("R7");
    for (int i = 0; i < 3; i++) step(1'b0, 16'h5555, 10 + i, "R7");
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 16'h6666, 1 + i, "R7");
    for (int i = 0; i < 12; i++) step(1'b1, 16'(i + 100), 4, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule